// File: doc/BRIEF.md
# Double-Buffered Serial Port with Interrupt Requests

This block is an asynchronous serial transmitter and receiver. Each direction has two stages: a holding register that the processor sees and a shift register that works on the line. The processor writes a byte into the transmit holding register. The transmitter copies that byte into its shifter as soon as the shifter is free, then reports that the holding register is empty again. The processor can therefore queue the next byte while the current one is still on the wire. On the receive side, each complete frame lands in the receive holding register while the next frame is already shifting in.

The line format is fixed: one low start bit, eight data bits with the LSB first, and one high stop bit. Bit timing comes from an external enable pulse at sixteen times the bit rate. The block raises three request outputs:
- receive-full, for a byte that is waiting to be read;
- transmit-empty, when the holding register can take the next byte;
- transmit-end, when the line has gone idle with nothing queued.

Each request is its flag gated by its own enable bit.

Top module: `dbsp_serial_port`

## Requirements
- R1: After reset the transmit line is high, `tx_empty` and `tx_end` are 1, and `rx_full`, `overrun` and all three request outputs are 0.
- R2: A transmitted frame is one low start bit, eight data bits LSB first and one high stop bit. Each bit lasts 16 `baud_tick` pulses, and the line is high whenever no frame is being sent.
- R3: A write pulse on `tx_wr` loads `tx_data` into the transmit holding register and clears both `tx_empty` and `tx_end`. If the shifter is idle, the byte moves into it on the next `baud_tick`, the start bit begins in that cycle, and `tx_empty` returns to 1. `tx_empty` never falls without a write.
- R4: If the holding register is full when the stop bit of the current frame ends, the next start bit follows immediately with no idle gap (frame starts exactly 160 ticks apart), and `tx_end` stays 0.
- R5: `tx_end` becomes 1 when the stop bit ends while `tx_empty` is 1, and only then.
- R6: When a frame is received with a high stop bit, and `rx_full` is 0, the byte appears on `rx_data` and `rx_full` becomes 1. The receiver samples RX at the middle of each bit.
- R7: A frame whose stop bit is sampled low is dropped: `rx_full` stays 0 and `rx_data` is unchanged.
- R8: A valid frame that completes while `rx_full` is 1 sets `overrun` and leaves `rx_data` holding the older byte.
- R9: A pulse on `rx_full_clr` clears `rx_full`, and a pulse on `overrun_clr` clears `overrun`.
- R10: `ie_we` loads `ie_in` into the enable register, where bit 0 enables receive-full, bit 1 enables transmit-empty and bit 2 enables transmit-end. Each request output is 1 exactly when its flag and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Enable pulse at 16x the bit rate |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| rx_data | output | 8 | Receive holding register |
| rx_full_clr | input | 1 | Clears the receive-full flag |
| overrun_clr | input | 1 | Clears the overrun flag |
| ie_we | input | 1 | Write strobe for the enable register |
| ie_in | input | 3 | Enable bits: [0] receive, [1] transmit-empty, [2] transmit-end |
| rx_full | output | 1 | Receive-full flag |
| tx_empty | output | 1 | Transmit holding register empty flag |
| tx_end | output | 1 | Transmit-end flag |
| overrun | output | 1 | Receive overrun flag |
| irq_rx | output | 1 | Receive-full request |
| irq_tx_empty | output | 1 | Transmit-empty request |
| irq_tx_end | output | 1 | Transmit-end request |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
The assertions check the flag rules on every cycle:
- a write clears the transmit-end flag;
- the transmit-empty flag falls only after a write;
- transmit-end rises only while the holding register is empty;
- an overrun never disturbs the held receive byte;
- a new byte is accepted only after a high stop-bit sample;
- the transmit-end request implies the transmit-empty flag.

The bench scenarios are what show the rest:
- the bit order and bit timing on the line;
- the gap-free handoff between consecutive frames;
- that a bad stop bit is dropped;
- that the request outputs follow the enables.

// File: rtl/dbsp_pkg.sv
package dbsp_pkg;
    typedef enum logic {TX_IDLE, TX_RUN} tx_st_e;
    typedef enum logic {RX_IDLE, RX_RUN} rx_st_e;
endpackage

// File: rtl/dbsp_tx.sv
module dbsp_tx
    import dbsp_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          txd,
    output logic          empty,
    output logic          tend
);
    localparam int FB = DW + 2;
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(FB);

    typedef struct packed {
        tx_st_e        st;
        logic [FB-1:0] sh;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bitn;
        logic [DW-1:0] hold;
        logic          empty;
        logic          tend;
    } tx_s;

    tx_s q, d;

    always_comb begin
        d = q;
        if (tick) begin
            case (q.st)
                TX_IDLE: begin
                    if (!q.empty) begin
                        d.st    = TX_RUN;
                        d.sh    = {1'b1, q.hold, 1'b0};
                        d.cnt   = '0;
                        d.bitn  = '0;
                        d.empty = 1'b1;
                    end
                end
                default: begin
                    if (q.cnt == CW'(OVS - 1)) begin
                        d.cnt = '0;
                        if (q.bitn == BW'(FB - 1)) begin
                            d.bitn = '0;
                            if (!q.empty) begin
                                d.sh    = {1'b1, q.hold, 1'b0};
                                d.empty = 1'b1;
                            end else begin
                                d.st   = TX_IDLE;
                                d.sh   = '1;
                                d.tend = 1'b1;
                            end
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                            d.sh   = {1'b1, q.sh[FB-1:1]};
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            endcase
        end
        if (wr) begin
            d.hold  = wdata;
            d.empty = 1'b0;
            d.tend  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= TX_IDLE;
            q.sh    <= '1;
            q.cnt   <= '0;
            q.bitn  <= '0;
            q.hold  <= '0;
            q.empty <= 1'b1;
            q.tend  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd   = (q.st == TX_RUN) ? q.sh[0] : 1'b1;
    assign empty = q.empty;
    assign tend  = q.tend;

    // R5
    tend_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tend) |-> empty);
    // R3
    wr_clears_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (!tend && !empty));
    // R3
    empty_falls_on_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty) |-> $past(wr));
endmodule

// File: rtl/dbsp_rx.sv
module dbsp_rx
    import dbsp_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          clr_full,
    input  logic          clr_ovr,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          ovr
);
    localparam int FB  = DW + 2;
    localparam int CW  = $clog2(OVS);
    localparam int BW  = $clog2(FB);
    localparam int MID = OVS / 2 - 1;

    typedef struct packed {
        logic          s1;
        logic          s2;
        rx_st_e        st;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bitn;
        logic [DW-1:0] sh;
        logic [DW-1:0] rdata;
        logic          full;
        logic          ovr;
    } rx_s;

    rx_s  q, d;
    logic at_sample;

    always_comb begin
        d    = q;
        d.s1 = rxd;
        d.s2 = q.s1;
        at_sample = (q.bitn == '0) ? (q.cnt == CW'(MID)) : (q.cnt == CW'(OVS - 1));
        if (clr_full) d.full = 1'b0;
        if (clr_ovr)  d.ovr  = 1'b0;
        if (tick) begin
            case (q.st)
                RX_IDLE: begin
                    if (!q.s2) begin
                        d.st   = RX_RUN;
                        d.cnt  = '0;
                        d.bitn = '0;
                    end
                end
                default: begin
                    if (at_sample) begin
                        d.cnt = '0;
                        if (q.bitn == '0) begin
                            if (q.s2) d.st = RX_IDLE;
                            else      d.bitn = 1;
                        end else if (q.bitn == BW'(FB - 1)) begin
                            d.st = RX_IDLE;
                            if (q.s2) begin
                                if (q.full) begin
                                    d.ovr = 1'b1;
                                end else begin
                                    d.rdata = q.sh;
                                    d.full  = 1'b1;
                                end
                            end
                        end else begin
                            d.sh   = {q.s2, q.sh[DW-1:1]};
                            d.bitn = q.bitn + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.s1    <= 1'b1;
            q.s2    <= 1'b1;
            q.st    <= RX_IDLE;
            q.cnt   <= '0;
            q.bitn  <= '0;
            q.sh    <= '0;
            q.rdata <= '0;
            q.full  <= 1'b0;
            q.ovr   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.rdata;
    assign full  = q.full;
    assign ovr   = q.ovr;

    // R8
    ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $stable(rdata));
    // R6
    full_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(q.s2));
endmodule

// File: rtl/dbsp_serial_port.sv
module dbsp_serial_port
    import dbsp_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    output logic [DW-1:0] rx_data,
    input  logic          rx_full_clr,
    input  logic          overrun_clr,
    input  logic          ie_we,
    input  logic [2:0]    ie_in,
    output logic          rx_full,
    output logic          tx_empty,
    output logic          tx_end,
    output logic          overrun,
    output logic          irq_rx,
    output logic          irq_tx_empty,
    output logic          irq_tx_end,
    output logic          txd,
    input  logic          rxd
);
    logic [2:0] ie_d, ie_q;

    always_comb begin
        ie_d = ie_q;
        if (ie_we) ie_d = ie_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ie_q <= '0;
        else        ie_q <= ie_d;
    end

    dbsp_tx #(.DW(DW), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .wr(tx_wr), .wdata(tx_data),
        .txd(txd), .empty(tx_empty), .tend(tx_end)
    );

    dbsp_rx #(.DW(DW), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd),
        .clr_full(rx_full_clr), .clr_ovr(overrun_clr),
        .rdata(rx_data), .full(rx_full), .ovr(overrun)
    );

    assign irq_rx       = rx_full  & ie_q[0];
    assign irq_tx_empty = tx_empty & ie_q[1];
    assign irq_tx_end   = tx_end   & ie_q[2];

    // R10
    end_req_implies_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_end |-> tx_empty);
endmodule

// File: tb/sim_dbsp_serial_port.sv
`timescale 1ns/1ps
module sim_dbsp_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic [7:0] rx_data;
    logic       rx_full_clr = 1'b0, overrun_clr = 1'b0, ie_we = 1'b0;
    logic [2:0] ie_in = '0;
    logic       rx_full, tx_empty, tx_end, overrun;
    logic       irq_rx, irq_tx_empty, irq_tx_end, txd;
    logic       rx_line = 1'b1;
    int         cyc = 0, n_chk = 0, n_bad = 0;
    bit         finished = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dbsp_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_data(rx_data), .rx_full_clr(rx_full_clr), .overrun_clr(overrun_clr),
        .ie_we(ie_we), .ie_in(ie_in), .rx_full(rx_full), .tx_empty(tx_empty),
        .tx_end(tx_end), .overrun(overrun), .irq_rx(irq_rx), .irq_tx_empty(irq_tx_empty),
        .irq_tx_end(irq_tx_end), .txd(txd), .rxd(rx_line)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic set_ie(input logic [2:0] v);
        ie_in = v;
        pulse(ie_we);
    endtask

    task automatic get_frame(output logic [7:0] b, output int ts, output logic stop);
        int guard = 0;
        while (txd !== 1'b0 && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        ts = cyc;
        repeat (7) @(negedge clk);
        chk(txd === 1'b0, "R2 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
            repeat (16) @(negedge clk);
            b[i] = txd;
        end
        repeat (16) @(negedge clk);
        stop = txd;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        logic [9:0] fr;
        fr = {stop, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            rx_line = fr[i];
            repeat (16) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(txd === 1'b1, "R1 txd", txd, 1);
        chk(tx_empty === 1'b1 && tx_end === 1'b1, "R1 tx flags", {tx_empty, tx_end}, 3);
        chk(rx_full === 1'b0 && overrun === 1'b0, "R1 rx flags", {rx_full, overrun}, 0);
        chk({irq_rx, irq_tx_empty, irq_tx_end} === 3'b000, "R1 irqs",
            {irq_rx, irq_tx_empty, irq_tx_end}, 0);
    endtask

    task automatic t_irq_gate();
        set_ie(3'b100);
        chk({irq_tx_empty, irq_tx_end} === 2'b01, "R10 end only", {irq_tx_empty, irq_tx_end}, 1);
        set_ie(3'b111);
        chk({irq_tx_empty, irq_tx_end} === 2'b11, "R10 both", {irq_tx_empty, irq_tx_end}, 3);
    endtask

    task automatic t_tx_single(input logic [7:0] v);
        logic [7:0] b;
        int ts;
        logic st;
        tx_data = v;
        pulse(tx_wr);
        chk(tx_empty === 1'b0 && tx_end === 1'b0, "R3 write clears", {tx_empty, tx_end}, 0);
        get_frame(b, ts, st);
        chk(b === v, "R2 data", b, v);
        chk(st === 1'b1, "R2 stop", st, 1);
        chk(tx_end === 1'b0, "R5 not early", tx_end, 0);
        repeat (10) @(negedge clk);
        chk(tx_end === 1'b1 && irq_tx_end === 1'b1, "R5 end set", {tx_end, irq_tx_end}, 3);
        chk(txd === 1'b1, "R2 idle high", txd, 1);
    endtask

    task automatic t_tx_b2b(input logic [7:0] v1, input logic [7:0] v2);
        logic [7:0] b;
        int t1, t2;
        logic st;
        tx_data = v1;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_data = v2;
        @(negedge clk);
        tx_wr = 1'b0;
        chk(tx_empty === 1'b0, "R3 second byte held", tx_empty, 0);
        get_frame(b, t1, st);
        chk(b === v1, "R4 first byte", b, v1);
        chk(tx_end === 1'b0, "R4 no end between", tx_end, 0);
        get_frame(b, t2, st);
        chk(t2 - t1 == 160, "R4 gap-free", t2 - t1, 160);
        chk(b === v2, "R4 second byte", b, v2);
        chk(tx_empty === 1'b1, "R3 empty after load", tx_empty, 1);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_rx_good(input logic [7:0] v);
        send_rx(v, 1'b1);
        chk(rx_full === 1'b1 && irq_rx === 1'b1, "R6 full", {rx_full, irq_rx}, 3);
        chk(rx_data === v, "R6 data", rx_data, v);
        pulse(rx_full_clr);
        chk(rx_full === 1'b0 && irq_rx === 1'b0, "R9 full clr", {rx_full, irq_rx}, 0);
    endtask

    task automatic t_rx_overrun(input logic [7:0] v1, input logic [7:0] v2);
        send_rx(v1, 1'b1);
        send_rx(v2, 1'b1);
        chk(overrun === 1'b1, "R8 overrun", overrun, 1);
        chk(rx_data === v1, "R8 keeps old", rx_data, v1);
        pulse(overrun_clr);
        chk(overrun === 1'b0 && rx_full === 1'b1, "R9 ovr clr", {overrun, rx_full}, 1);
        pulse(rx_full_clr);
    endtask

    task automatic t_rx_badstop(input logic [7:0] v, input logic [7:0] prev);
        send_rx(v, 1'b0);
        repeat (40) @(negedge clk);
        chk(rx_full === 1'b0, "R7 dropped", rx_full, 0);
        chk(rx_data === prev, "R7 data unchanged", rx_data, prev);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_irq_gate();
        t_tx_single(8'hA5);
        t_tx_b2b(8'h3C, 8'hC3);
        t_rx_good(8'h5A);
        t_rx_overrun(8'h11, 8'h22);
        t_rx_badstop(8'h77, 8'h11);
        report();
    end
endmodule